// File: doc/BRIEF.md
# Cell Delineation Loss Persistence Monitor

This block tracks the sync status of a set of cell delineation engines and decides, port by port, when a lost delineation has lasted long enough to count as an alarm. It also decides when a regained delineation has lasted long enough to clear that alarm. Each port has its own down-counter. The counter runs on a timebase tick, not on every clock. It is loaded from one shared preload value whenever the port's sync indication changes in a way that matters.

One shared enable switches all the counters on. When the enable is low, every counter is held at zero, no interrupt is raised, and each port's alarm simply mirrors the inverse of its raw sync input, one clock later. The block also carries a per-port force-hunt path. A processor write strobe for a port is turned into a single-cycle request toward that port's delineation logic.

Each port runs a four-state machine:

| State | Alarm | Meaning |
|---|---|---|
| WORK_SYNC | 0 | Working and in sync |
| WORK_LOSS | 0 | Working, but sync is lost and the entry count is running |
| ALARM_LOSS | 1 | Alarm, and sync is still lost |
| ALARM_REGAIN | 1 | Alarm, but sync is back and the exit count is running |

The transitions are:

| From | To | Condition | Effect |
|---|---|---|---|
| WORK_SYNC | WORK_LOSS | sync drops | Counter loads |
| WORK_LOSS | WORK_SYNC | sync returns | Counter clears |
| WORK_LOSS | ALARM_LOSS | counter expires | Start pulse |
| ALARM_LOSS | ALARM_REGAIN | sync returns | Counter loads |
| ALARM_REGAIN | ALARM_LOSS | sync drops | Counter clears |
| ALARM_REGAIN | WORK_SYNC | counter expires | End pulse |

When the enable is low, every state goes to WORK_SYNC if the port is in sync and to ALARM_LOSS if it is not.

Top module: `lcd_persist_mon`

## Requirements
- R1: After reset, all alarm, start, end and hunt outputs are 0.
- R2: With the enable high, a port that drops sync and stays out of sync through N timebase ticks gets alarm_o=1. Here N is preload_i, or 1 when preload_i is 0. Alarm rises at the clock edge that samples the Nth tick, and irq_start_o for that port pulses at that same edge.
- R3: If sync returns before the Nth tick, no alarm is raised and the count is discarded. A later loss again needs the full N ticks.
- R4: A port in alarm that regains sync and keeps it through N ticks returns to alarm_o=0. irq_end_o pulses at the edge that samples the Nth tick.
- R5: Losing sync while the exit count is running keeps the alarm set and discards the count. Ticks do nothing while sync is absent in alarm, and a fresh regain needs the full N ticks.
- R6: Ports are independent. Stimulus on one port changes no output bit of any other port.
- R7: With the enable low, no start or end pulse is issued. alarm_o follows the inverse of sync_i, registered once.
- R8: A preload of 0 acts as a period of one tick.
- R9: A 1 on hunt_set_i[p] gives hunt_o[p]=1 for exactly the next clock cycle, and only for port p.
- R10: Start and end pulses last exactly one clock cycle.
- R11: Clock cycles without a tick never advance a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global persistence enable |
| preload_i | input | CNT_W | Shared period in ticks |
| tick_i | input | 1 | Timebase tick, one clock wide |
| sync_i | input | NPORT | Per-port in-sync indication |
| hunt_set_i | input | NPORT | Per-port processor force-hunt strobe |
| alarm_o | output | NPORT | Per-port loss-of-delineation alarm |
| irq_start_o | output | NPORT | Alarm entry pulse |
| irq_end_o | output | NPORT | Alarm exit pulse |
| hunt_o | output | NPORT | Forwarded one-cycle hunt request |

## Verification
The assertions assume that tick_i is sampled only at clock edges. They also assume that preload_i is held steady while a count runs, because they link an expiry only to a tick and a sync level seen one cycle earlier. The stimulus changes sync, enable and preload only at falling clock edges. It changes preload only while all ports are in sync. It raises the tick for a single cycle at a time, so every count starts from a known load.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        ST_WORK_SYNC    = 2'd0,
        ST_WORK_LOSS    = 2'd1,
        ST_ALARM_LOSS   = 2'd2,
        ST_ALARM_REGAIN = 2'd3
    } lcd_state_t;

endpackage

// File: rtl/lcd_timer.sv
module lcd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // A zero preload would never expire, so it is treated as one tick.
    assign load_val = (preload_i == '0) ? ONE : preload_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // The tick that takes the count from one to zero is the expiry.
    assign expire_o = tick_i && (cnt_q == ONE);

endmodule

// File: rtl/lcd_port_fsm.sv
module lcd_port_fsm
    import lcd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preload_i,
    input  logic             sync_i,
    output logic             alarm_o,
    output logic             irq_start_o,
    output logic             irq_end_o
);
    lcd_state_t st_q, st_d;
    logic       ld, cl, exp_w, start_ev, end_ev;

    lcd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cl),
        .load_i    (ld),
        .tick_i    (tick_i),
        .preload_i (preload_i),
        .expire_o  (exp_w)
    );

    // Next-state and timer-control logic
    always_comb begin
        st_d     = st_q;
        ld       = 1'b0;
        cl       = 1'b0;
        start_ev = 1'b0;
        end_ev   = 1'b0;
        if (!en_i) begin
            cl   = 1'b1;
            st_d = sync_i ? ST_WORK_SYNC : ST_ALARM_LOSS;
        end else begin
            unique case (st_q)
                ST_WORK_SYNC: begin
                    if (!sync_i) begin
                        st_d = ST_WORK_LOSS;
                        ld   = 1'b1;
                    end
                end
                ST_WORK_LOSS: begin
                    if (sync_i) begin
                        st_d = ST_WORK_SYNC;
                        cl   = 1'b1;
                    end else if (exp_w) begin
                        st_d     = ST_ALARM_LOSS;
                        start_ev = 1'b1;
                    end
                end
                ST_ALARM_LOSS: begin
                    if (sync_i) begin
                        st_d = ST_ALARM_REGAIN;
                        ld   = 1'b1;
                    end
                end
                ST_ALARM_REGAIN: begin
                    if (!sync_i) begin
                        st_d = ST_ALARM_LOSS;
                        cl   = 1'b1;
                    end else if (exp_w) begin
                        st_d   = ST_WORK_SYNC;
                        end_ev = 1'b1;
                    end
                end
                default: st_d = ST_WORK_SYNC;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WORK_SYNC;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_start_o <= 1'b0;
            irq_end_o   <= 1'b0;
        end else begin
            irq_start_o <= start_ev;
            irq_end_o   <= end_ev;
        end
    end

    assign alarm_o = (st_q == ST_ALARM_LOSS) || (st_q == ST_ALARM_REGAIN);

    p_start_in_alarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start_o |-> (st_q == ST_ALARM_LOSS));
    p_start_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start_o |-> ($past(tick_i) && !$past(sync_i)));
    p_end_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end_o |-> (st_q == ST_WORK_SYNC && $past(sync_i) && $past(tick_i)));
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!irq_start_o && !irq_end_o));
    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start_o |=> !irq_start_o);
    p_end_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end_o |=> !irq_end_o);
    p_regain_loss_keeps_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q == ST_ALARM_REGAIN && !sync_i) |=> alarm_o);

endmodule

// File: rtl/lcd_hunt_ctl.sv
module lcd_hunt_ctl #(
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] set_i,
    output logic [NPORT-1:0] hunt_o
);
    // Each request bit lives for one cycle and clears itself.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hunt_o <= '0;
        else        hunt_o <= set_i;
    end

    p_hunt_from_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_o != '0) |-> ((hunt_o & ~$past(set_i)) == '0));

endmodule

// File: rtl/lcd_persist_mon.sv
module lcd_persist_mon #(
    parameter int NPORT = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] preload_i,
    input  logic             tick_i,
    input  logic [NPORT-1:0] sync_i,
    input  logic [NPORT-1:0] hunt_set_i,
    output logic [NPORT-1:0] alarm_o,
    output logic [NPORT-1:0] irq_start_o,
    output logic [NPORT-1:0] irq_end_o,
    output logic [NPORT-1:0] hunt_o
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        lcd_port_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (en_i),
            .tick_i      (tick_i),
            .preload_i   (preload_i),
            .sync_i      (sync_i[p]),
            .alarm_o     (alarm_o[p]),
            .irq_start_o (irq_start_o[p]),
            .irq_end_o   (irq_end_o[p])
        );
    end

    lcd_hunt_ctl #(.NPORT(NPORT)) u_hunt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hunt_set_i),
        .hunt_o (hunt_o)
    );

    p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_start_o & irq_end_o) == '0);

endmodule

// File: tb/lcd_persist_mon_bench.sv
module lcd_persist_mon_bench;
    localparam int NP = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] preload = '0;
    logic          tick = 1'b0;
    logic [NP-1:0] sync = '1;
    logic [NP-1:0] hset = '0;
    logic [NP-1:0] alarm, istart, iend, hunt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lcd_persist_mon #(.NPORT(NP), .CNT_W(CW)) u_lcd_persist_mon (
        .clk(clk), .rst_n(rst_n), .en_i(en), .preload_i(preload), .tick_i(tick),
        .sync_i(sync), .hunt_set_i(hset), .alarm_o(alarm), .irq_start_o(istart),
        .irq_end_o(iend), .hunt_o(hunt)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick1();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: the reset state
        expect_eq("R1 alarm", 32'(alarm), 0);
        expect_eq("R1 irq", 32'({istart, iend}), 0);
        expect_eq("R1 hunt", 32'(hunt), 0);
        en = 1'b1;
        step();

        // Sweep the preload over 0..4 on port 0
        for (int pv = 0; pv <= 4; pv++) begin
            int eff;
            eff = (pv == 0) ? 1 : pv;
            preload = CW'(pv);
            step();
            // R11: cycles without a tick leave the count alone
            sync[0] = 1'b0;
            repeat (6) step();
            expect_eq("R11 no tick no alarm", 32'(alarm), 0);
            sync[0] = 1'b1;
            step();
            // R3: partial losses
            for (int lt = 0; lt < eff; lt++) begin
                sync[0] = 1'b0;
                step();
                repeat (lt) tick1();
                expect_eq("R3 partial loss", 32'(alarm), 0);
                sync[0] = 1'b1;
                step();
                expect_eq("R3 recovered", 32'({alarm, istart}), 0);
            end
            // R2/R8: a full loss
            sync[0] = 1'b0;
            step();
            repeat (eff - 1) tick1();
            expect_eq("R3 count restarted", 32'(alarm), 0);
            tick1();
            expect_eq(pv == 0 ? "R8 alarm" : "R2 alarm", 32'(alarm), 32'h1);
            expect_eq("R2 start pulse", 32'(istart), 32'h1);
            step();
            expect_eq("R10 start one cycle", 32'(istart), 0);
            expect_eq("R6 other ports", 32'(alarm), 32'h1);
            // R4/R5: exit count interrupted, then completed
            sync[0] = 1'b1;
            step();
            repeat (eff - 1) tick1();
            expect_eq("R4 still alarm", 32'({alarm, iend}), 32'h10);
            sync[0] = 1'b0;
            step();
            expect_eq("R5 loss keeps alarm", 32'({alarm, iend}), 32'h10);
            repeat (eff) tick1();
            expect_eq("R5 ticks in loss", 32'({alarm, istart, iend}), 32'h100);
            sync[0] = 1'b1;
            step();
            repeat (eff - 1) tick1();
            expect_eq("R5 full regain needed", 32'(alarm), 32'h1);
            tick1();
            expect_eq("R4 alarm cleared", 32'(alarm), 0);
            expect_eq("R4 end pulse", 32'(iend), 32'h1);
            step();
            expect_eq("R10 end one cycle", 32'(iend), 0);
        end

        // R6: two ports with staggered losses
        preload = CW'(2);
        step();
        sync[1] = 1'b0;
        step();
        tick1();
        sync[2] = 1'b0;
        step();
        tick1();
        expect_eq("R6 port1 only", 32'({alarm, istart}), 32'h22);
        tick1();
        expect_eq("R6 port2 follows", 32'({alarm, istart}), 32'h64);
        sync[1] = 1'b1;
        sync[2] = 1'b1;
        step();
        tick1();
        tick1();
        expect_eq("R6 both cleared", 32'({alarm, iend}), 32'h06);

        // R7: with the enable low, alarm mirrors sync
        en = 1'b0;
        step();
        sync[3] = 1'b0;
        step();
        expect_eq("R7 alarm mirrors", 32'({alarm, istart, iend}), 32'h800);
        tick1();
        tick1();
        expect_eq("R7 no start", 32'({alarm, istart, iend}), 32'h800);
        sync[3] = 1'b1;
        step();
        expect_eq("R7 no end", 32'({alarm, istart, iend}), 0);
        en = 1'b1;
        step();

        // R9: the force-hunt pulse
        for (int p = 0; p < NP; p++) begin
            hset = NP'(1) << p;
            step();
            hset = '0;
            expect_eq("R9 hunt pulse", 32'(hunt), 32'(1 << p));
            step();
            expect_eq("R9 hunt clears", 32'(hunt), 0);
        end

        finish_run();
    end
endmodule